// File: doc/BRIEF.md
# Dual-Channel Compare Timer with PWM

This block is an 8-bit timer/counter with two compare channels, A and B. Each channel drives one waveform pin. The counter runs in one of four modes:

- **Free-running:** the counter wraps from 0xFF to 0.
- **Clear-on-match:** channel A's compare value sets the period.
- **Single-slope PWM:** the counter counts up and wraps.
- **Dual-slope PWM:** the counter counts up to 0xFF, then back down to 0, giving symmetric PWM.

The counter only moves when a timer tick is present. A clock-select field picks the tick source: none, an internal prescaled tick input, or an edge of an external pin. The external pin is first passed through a two-stage synchronizer. The edge used can be rising or falling.

Software reaches the block through a flat register port: a write strobe, a 3-bit address, write data, and combinational read data.

- **Compare values:** each channel keeps a buffer that software writes. In the PWM modes the working compare value is copied from that buffer once per counter period, so a new duty cycle never cuts a pulse short. In the other two modes a write takes effect at once.
- **Events and interrupt:** overflow, match A and match B each set a sticky flag. Each flag has its own mask bit. One interrupt line reports any flag that is both set and unmasked.

Top module: `dual_cmp_timer`

## Requirements
- R1: After reset, every register reads zero and wave_a, wave_b and irq are low. The address map is:
  - 0: control, with mode in bits [1:0] and tick source in bits [3:2].
  - 1: counter.
  - 2: compare A (reads the buffer).
  - 3: compare B (reads the buffer).
  - 4: flags, with overflow in bit 0, match A in bit 1 and match B in bit 2.
  - 5: mask, with the same bit layout as flags.
- R2: Tick source code 0 stops the counter, whatever happens on tick_in or ext_pin. With code 1, each clock cycle in which tick_in is high advances the counter, and the new value is visible after that clock edge.
- R3: Code 2 counts rising edges of ext_pin and code 3 counts falling edges. Each edge advances the counter once. The new count is visible after the third clock edge that follows the pin change. A transition of the other polarity does not advance the counter.
- R4: In mode 0 (free-running), the counter counts up and wraps from 0xFF to 0. The tick that performs the wrap sets the overflow flag.
- R5: In mode 1 (clear-on-match), a tick taken while the counter equals compare A loads 0 instead of incrementing.
- R6: In modes 2 and 3, a compare write only fills the buffer. The working value takes the buffer's contents on the tick taken at count 0xFF. In modes 0 and 1, a compare write updates the working value at once.
- R7: In mode 2 (single-slope PWM), the wrap tick drives the channel output high, and a compare match drives it low. When both happen on the same tick, the high wins, so a compare value of 0xFF keeps the output permanently high.
- R8: In mode 3 (dual-slope PWM), the counter counts up to 0xFF and then down to 0. A match while counting up drives the output low, and a match while counting down drives it high. The overflow flag is set by the tick taken at count 0 and not by the tick at 0xFF.
- R9: In modes 0 and 1, every compare match toggles that channel's output.
- R10: A tick whose pre-advance count equals a channel's working compare value sets that channel's match flag. Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged.
- R11: irq is high exactly when some flag and its mask bit are both 1.
- R12: Writing the counter suppresses compare matches on the first tick after the write. Neither the match flag nor the output changes on that tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for read and write |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr (combinational) |
| tick_in | input | 1 | Internal prescaled tick |
| ext_pin | input | 1 | Asynchronous external count pin |
| wave_a | output | 1 | Channel A waveform |
| wave_b | output | 1 | Channel B waveform |
| irq | output | 1 | Masked interrupt request |

## Verification
With the internal source, a count, a flag or a waveform change appears after the same clock edge that samples tick_in high. The bench raises tick_in on a falling edge, holds it for exactly N rising edges, and reads the results on the next falling edge.

With the external source, the count moves after the third rising edge that follows the pin change. The bench reads the counter after the second edge, expecting no change, and again after the third, expecting the new value.

Register reads are combinational, so they are sampled one nanosecond after the address is set on a falling edge. Each PWM check is placed at a count worked out from the requirements: just before and just after the compare value, and on either side of the load points at 0xFF and 0.

// File: rtl/dct_pkg.sv
package dct_pkg;

    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 3;
    localparam int N_CHAN  = 2;
    localparam int N_FLAG  = N_CHAN + 1;

    typedef enum logic [1:0] {
        MD_FREE  = 2'd0,
        MD_CTC   = 2'd1,
        MD_FPWM  = 2'd2,
        MD_PCPWM = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        CK_OFF      = 2'd0,
        CK_INT      = 2'd1,
        CK_EXT_RISE = 2'd2,
        CK_EXT_FALL = 2'd3
    } clk_sel_e;

    typedef struct packed {
        clk_sel_e src;
        mode_e    md;
    } ctrl_t;

    localparam logic [ADDR_W-1:0] RA_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] RA_CNT  = 3'd1;
    localparam logic [ADDR_W-1:0] RA_CMPA = 3'd2;
    localparam logic [ADDR_W-1:0] RA_CMPB = 3'd3;
    localparam logic [ADDR_W-1:0] RA_FLAG = 3'd4;
    localparam logic [ADDR_W-1:0] RA_MASK = 3'd5;

    function automatic logic is_pwm(mode_e m);
        return (m == MD_FPWM) || (m == MD_PCPWM);
    endfunction

endpackage

// File: rtl/dct_clk_sel.sv
module dct_clk_sel
    import dct_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  clk_sel_e src,
    input  logic     tick_in,
    input  logic     ext_pin,
    output logic     ext_edge,
    output logic     tick
);
    // Synchronizer stages, plus one extra stage holding the previous value.
    logic [SYNC_STAGES:0] shr;
    logic pin_now, pin_prev;

    always_ff @(posedge clk) begin
        if (rst) shr <= '0;
        else     shr <= {shr[SYNC_STAGES-1:0], ext_pin};
    end

    assign pin_now  = shr[SYNC_STAGES-1];
    assign pin_prev = shr[SYNC_STAGES];

    always_comb begin
        unique case (src)
            CK_EXT_RISE: ext_edge = pin_now & ~pin_prev;
            CK_EXT_FALL: ext_edge = ~pin_now & pin_prev;
            default:     ext_edge = 1'b0;
        endcase
        unique case (src)
            CK_OFF:  tick = 1'b0;
            CK_INT:  tick = tick_in;
            default: tick = ext_edge;
        endcase
    end

endmodule

// File: rtl/dct_counter.sv
module dct_counter
    import dct_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  mode_e        mode,
    input  logic         tick,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic [W-1:0] ctc_top,
    output logic [W-1:0] cnt,
    output logic         cnt_up,
    output logic         at_max,
    output logic         ovf_evt
);
    localparam logic [W-1:0] MAXV = '1;
    localparam logic [W-1:0] ZERO = '0;

    logic         dir_up_q;
    logic [W-1:0] cnt_nx;

    assign at_max = (cnt == MAXV);

    // Direction as seen this tick: the end points force the turn.
    assign cnt_up = (cnt == ZERO) ? 1'b1 : (at_max ? 1'b0 : dir_up_q);

    always_comb begin
        unique case (mode)
            MD_CTC:   cnt_nx = (cnt == ctc_top) ? ZERO : cnt + 1'b1;
            MD_PCPWM: cnt_nx = cnt_up ? cnt + 1'b1 : cnt - 1'b1;
            default:  cnt_nx = cnt + 1'b1;
        endcase
    end

    assign ovf_evt = tick && !ld &&
                     ((mode == MD_PCPWM) ? (cnt == ZERO) : at_max);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= ZERO;
            dir_up_q <= 1'b1;
        end else if (ld) begin
            cnt <= ld_val;
        end else if (tick) begin
            cnt      <= cnt_nx;
            dir_up_q <= cnt_up;
        end
    end

endmodule

// File: rtl/dct_cmp_chan.sv
module dct_cmp_chan
    import dct_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  mode_e        mode,
    input  logic         tick,
    input  logic         blk,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] cnt,
    input  logic         cnt_up,
    input  logic         at_max,
    output logic [W-1:0] ocr_buf,
    output logic [W-1:0] ocr_act,
    output logic         match,
    output logic         wave
);
    logic reload;

    assign reload = is_pwm(mode) && tick && at_max;
    assign match  = tick && !blk && (cnt == ocr_act);

    always_ff @(posedge clk) begin
        if (rst) begin
            ocr_buf <= '0;
            ocr_act <= '0;
        end else begin
            if (wr) ocr_buf <= wdata;
            if (wr && !is_pwm(mode)) ocr_act <= wdata;
            else if (reload)         ocr_act <= ocr_buf;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wave <= 1'b0;
        end else begin
            unique case (mode)
                MD_FPWM: begin
                    if (tick && at_max) wave <= 1'b1;
                    else if (match)     wave <= 1'b0;
                end
                MD_PCPWM: begin
                    if (match) wave <= !cnt_up;
                end
                default: begin
                    if (match) wave <= !wave;
                end
            endcase
        end
    end

endmodule

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer
    import dct_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              tick_in,
    input  logic              ext_pin,
    output logic              wave_a,
    output logic              wave_b,
    output logic              irq
);
    localparam int W = DATA_W;

    ctrl_t               ctrl_q;
    logic [N_FLAG-1:0]   flags_q, mask_q, flag_set, flag_clr;
    logic                blk_q, tick, ext_edge, cnt_wr;
    logic [W-1:0]        cnt;
    logic                cnt_up, at_max, ovf_evt;
    logic [N_CHAN-1:0][W-1:0] ocr_buf, ocr_act;
    logic [N_CHAN-1:0]   match, wave;

    assign cnt_wr = wr_en && (addr == RA_CNT);

    dct_clk_sel #(.SYNC_STAGES(2)) u_clk_sel (
        .clk(clk), .rst(rst), .src(ctrl_q.src), .tick_in(tick_in),
        .ext_pin(ext_pin), .ext_edge(ext_edge), .tick(tick)
    );

    dct_counter #(.W(W)) u_cnt (
        .clk(clk), .rst(rst), .mode(ctrl_q.md), .tick(tick),
        .ld(cnt_wr), .ld_val(wdata), .ctc_top(ocr_act[0]),
        .cnt(cnt), .cnt_up(cnt_up), .at_max(at_max), .ovf_evt(ovf_evt)
    );

    for (genvar g = 0; g < N_CHAN; g++) begin : g_chan
        dct_cmp_chan #(.W(W)) u_chan (
            .clk(clk), .rst(rst), .mode(ctrl_q.md), .tick(tick),
            .blk(blk_q),
            .wr(wr_en && (addr == RA_CMPA + ADDR_W'(g))),
            .wdata(wdata), .cnt(cnt), .cnt_up(cnt_up), .at_max(at_max),
            .ocr_buf(ocr_buf[g]), .ocr_act(ocr_act[g]),
            .match(match[g]), .wave(wave[g])
        );
    end

    assign wave_a   = wave[0];
    assign wave_b   = wave[1];
    assign flag_set = {match, ovf_evt};
    assign flag_clr = (wr_en && addr == RA_FLAG) ? wdata[N_FLAG-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            mask_q  <= '0;
            flags_q <= '0;
            blk_q   <= 1'b0;
        end else begin
            if (wr_en && addr == RA_CTRL) ctrl_q <= ctrl_t'(wdata[3:0]);
            if (wr_en && addr == RA_MASK) mask_q <= wdata[N_FLAG-1:0];
            flags_q <= (flags_q & ~flag_clr) | flag_set;
            if (cnt_wr)    blk_q <= 1'b1;
            else if (tick) blk_q <= 1'b0;
        end
    end

    assign irq = |(flags_q & mask_q);

    always_comb begin
        unique case (addr)
            RA_CTRL: rdata = W'(ctrl_q);
            RA_CNT:  rdata = cnt;
            RA_CMPA: rdata = ocr_buf[0];
            RA_CMPB: rdata = ocr_buf[1];
            RA_FLAG: rdata = W'(flags_q);
            RA_MASK: rdata = W'(mask_q);
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/dct_chk.sv
module dct_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] mode,
    input logic       tick,
    input logic       cnt_wr,
    input logic [7:0] cnt,
    input logic [7:0] cmpa_act,
    input logic [1:0] match,
    input logic [2:0] flags,
    input logic       ext_edge
);
    AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!tick && !cnt_wr) |=> $stable(cnt)); // R2

    AST_EXT_PULSE: assert property (@(posedge clk) disable iff (rst)
        ext_edge |=> !ext_edge); // R3

    AST_FREE_OVF: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd0 && tick && !cnt_wr && cnt == 8'hFF) |=> flags[0]); // R4

    AST_CTC_RELOAD: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd1 && tick && !cnt_wr && cnt == cmpa_act) |=> cnt == 8'h00); // R5

    AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd3 && tick && !cnt_wr) |=>
        (cnt == 8'($past(cnt) + 8'd1) || cnt == 8'($past(cnt) - 8'd1))); // R8

    AST_WRITE_BLOCK: assert property (@(posedge clk) disable iff (rst)
        cnt_wr |=> match == 2'b00); // R12
endmodule

bind dual_cmp_timer dct_chk u_chk (
    .clk(clk), .rst(rst), .mode(ctrl_q.md), .tick(tick), .cnt_wr(cnt_wr),
    .cnt(cnt), .cmpa_act(ocr_act[0]), .match(match), .flags(flags_q),
    .ext_edge(ext_edge)
);

// File: tb/dual_cmp_timer_tb.sv
`timescale 1ns/1ps
module dual_cmp_timer_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       tick_in = 1'b0;
    logic       ext_pin = 1'b0;
    logic       wave_a, wave_b, irq;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dual_cmp_timer u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .tick_in(tick_in), .ext_pin(ext_pin),
        .wave_a(wave_a), .wave_b(wave_b), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic ticks(input int n);
        tick_in = 1'b1;
        repeat (n) @(negedge clk);
        tick_in = 1'b0;
    endtask

    task automatic chk_reg(input string req, input logic [2:0] a, input logic [7:0] exp);
        logic [7:0] v;
        rd_reg(a, v);
        chk(req, {24'd0, v}, {24'd0, exp});
    endtask

    task automatic t_reset;
        @(negedge clk);
        for (int a = 0; a < 6; a++) chk_reg("R1 reset reg", 3'(a), 8'h00);
        chk("R1 reset outputs", {29'd0, wave_a, wave_b, irq}, 32'd0);
    endtask

    task automatic t_clock_select;
        wr_reg(3'd0, 8'h00);           // source off, free mode
        ticks(5);
        chk_reg("R2 stopped", 3'd1, 8'h00);
        wr_reg(3'd0, 8'h04);           // internal tick
        wr_reg(3'd1, 8'h50);
        ticks(1);
        chk_reg("R2 single tick", 3'd1, 8'h51);
    endtask

    task automatic t_free_ovf;
        wr_reg(3'd4, 8'h07);
        wr_reg(3'd1, 8'hFD);
        ticks(2);
        chk_reg("R4 count FF", 3'd1, 8'hFF);
        chk_reg("R4 no ovf yet", 3'd4, 8'h00);
        ticks(1);
        chk_reg("R4 wrap", 3'd1, 8'h00);
        chk_reg("R4 ovf flag", 3'd4, 8'h01);
    endtask

    task automatic t_flags_irq;
        chk("R11 masked irq", {31'd0, irq}, 32'd0);
        wr_reg(3'd5, 8'h01);
        chk("R11 unmasked irq", {31'd0, irq}, 32'd1);
        wr_reg(3'd4, 8'h02);
        chk_reg("R10 write 0 keeps", 3'd4, 8'h01);
        wr_reg(3'd4, 8'h01);
        chk_reg("R10 write 1 clears", 3'd4, 8'h00);
        chk("R11 irq drops", {31'd0, irq}, 32'd0);
        wr_reg(3'd5, 8'h00);
    endtask

    task automatic t_ctc;
        wr_reg(3'd2, 8'h05);
        wr_reg(3'd3, 8'h77);
        wr_reg(3'd0, 8'h05);           // internal, clear-on-match
        wr_reg(3'd1, 8'h00);
        wr_reg(3'd4, 8'h07);
        ticks(5);
        chk_reg("R5 reach top", 3'd1, 8'h05);
        chk_reg("R10 no flag before match", 3'd4, 8'h00);
        ticks(1);
        chk_reg("R5 reload zero", 3'd1, 8'h00);
        chk_reg("R10 match A flag", 3'd4, 8'h02);
        chk("R9 toggle high", {31'd0, wave_a}, 32'd1);
        ticks(6);
        chk_reg("R5 second period", 3'd1, 8'h00);
        chk("R9 toggle low", {31'd0, wave_a}, 32'd0);
    endtask

    task automatic t_block;
        wr_reg(3'd0, 8'h04);
        wr_reg(3'd2, 8'h20);
        wr_reg(3'd4, 8'h07);
        wr_reg(3'd1, 8'h20);
        ticks(1);
        chk_reg("R12 count moved", 3'd1, 8'h21);
        chk_reg("R12 flag blocked", 3'd4, 8'h00);
        chk("R12 wave held", {31'd0, wave_a}, 32'd0);
        wr_reg(3'd1, 8'h1F);
        ticks(2);
        chk_reg("R12 later match flag", 3'd4, 8'h02);
        chk("R9 later match toggles", {31'd0, wave_a}, 32'd1);
    endtask

    task automatic t_fpwm;
        logic [7:0] v;
        int lows;
        wr_reg(3'd3, 8'h10);           // direct, free mode
        wr_reg(3'd4, 8'h07);
        wr_reg(3'd0, 8'h06);           // internal, single-slope PWM
        wr_reg(3'd3, 8'h40);           // buffered
        chk_reg("R1 compare B reads buffer", 3'd3, 8'h40);
        wr_reg(3'd1, 8'h0E);
        ticks(3);
        chk_reg("R6 old value still matches", 3'd4, 8'h04);
        chk("R7 cleared at match", {31'd0, wave_b}, 32'd0);
        ticks(239);
        chk_reg("R7 wrapped", 3'd1, 8'h00);
        chk("R7 set at wrap", {31'd0, wave_b}, 32'd1);
        ticks(8'h40);
        chk("R6 new value loaded at wrap", {31'd0, wave_b}, 32'd1);
        ticks(1);
        chk("R7 cleared at new match", {31'd0, wave_b}, 32'd0);
        wr_reg(3'd2, 8'hFF);
        ticks(191);
        rd_reg(3'd1, v);
        chk("R7 at bottom", {24'd0, v}, 32'h00);
        lows = 0;
        tick_in = 1'b1;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (wave_a !== 1'b1) lows++;
        end
        tick_in = 1'b0;
        chk("R7 full duty stays high", lows, 0);
    endtask

    task automatic t_pcpwm;
        wr_reg(3'd0, 8'h04);
        wr_reg(3'd3, 8'h80);           // direct
        wr_reg(3'd0, 8'h07);           // internal, dual-slope
        wr_reg(3'd1, 8'h01);
        wr_reg(3'd3, 8'h60);           // buffered until top
        wr_reg(3'd4, 8'h07);
        ticks(254);
        chk_reg("R8 reach top", 3'd1, 8'hFF);
        chk("R8 up match clears", {31'd0, wave_b}, 32'd0);
        chk_reg("R8 no ovf at top", 3'd4, 8'h04);
        ticks(159);
        chk_reg("R8 counting down", 3'd1, 8'h60);
        chk("R6 old value no longer active", {31'd0, wave_b}, 32'd0);
        ticks(1);
        chk("R8 down match sets", {31'd0, wave_b}, 32'd1);
        ticks(95);
        chk_reg("R8 bottom", 3'd1, 8'h00);
        wr_reg(3'd4, 8'h07);
        ticks(1);
        chk_reg("R8 turns up", 3'd1, 8'h01);
        chk_reg("R8 ovf at bottom", 3'd4, 8'h01);
    endtask

    task automatic t_ext;
        wr_reg(3'd0, 8'h08);           // rising edge of pin
        wr_reg(3'd1, 8'h00);
        ext_pin = 1'b1;
        @(negedge clk); @(negedge clk);
        chk_reg("R3 not yet after two edges", 3'd1, 8'h00);
        @(negedge clk);
        chk_reg("R3 counted after three edges", 3'd1, 8'h01);
        ext_pin = 1'b0;
        repeat (4) @(negedge clk);
        chk_reg("R3 falling ignored", 3'd1, 8'h01);
        wr_reg(3'd0, 8'h0C);           // falling edge of pin
        ext_pin = 1'b1;
        repeat (4) @(negedge clk);
        chk_reg("R3 rising ignored", 3'd1, 8'h01);
        ext_pin = 1'b0;
        repeat (4) @(negedge clk);
        chk_reg("R3 falling counted", 3'd1, 8'h02);
    endtask

    task automatic report;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            miscompares++;
            vectors++;
            $display("FAIL watchdog: actual hung expected finished");
            report();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_clock_select();
        t_free_ovf();
        t_flags_irq();
        t_ctc();
        t_block();
        t_fpwm();
        t_pcpwm();
        t_ext();
        done = 1'b1;
        report();
    end
endmodule